// File: doc/BRIEF.md
# Output-Buffered Packet Switch with ACK/NACK Links

This block is a packet switch for a synchronous on-chip network. It takes flit streams on a configurable number of input links and forwards them to a separately configurable number of output links, so the switch does not have to be square. Every flit carries a head marker and a tail marker next to its payload. The head flit of each packet holds the source route. The switch reads the next output port from the lowest route bits and shifts the route right for the next hop. Body and tail flits then follow the output that the head chose.

Flits are buffered at the outputs: each output link owns a FIFO. Each incoming flit is answered one cycle later, either with ACK (the flit was accepted) or with NACK (the flit was refused and the sender must send it again). An output that accepts a head flit without a tail marker is locked to that input until the tail is accepted. This keeps packets from interleaving. When several head flits compete for an unlocked output, a rotating priority picks the winner. Downstream, each output shows the flit at the front of its FIFO and keeps it there until the receiver acknowledges it.

Top module: `noc_sw_switch`

## Requirements
- R1: A flit is FLIT_W = DATA_W+2 bits: bit FLIT_W-1 is the head marker, bit FLIT_W-2 the tail marker, bits DATA_W-1:0 the payload. A head flit goes to the output numbered by payload bits SEL_W-1:0 (SEL_W = clog2(N_OUT), at least 1). It leaves with both markers unchanged and its payload shifted right by SEL_W with zero fill.
- R2: A cycle with in_valid high on an input is answered in the next cycle by exactly one of in_ack or in_nack on that input. A cycle without in_valid is answered by neither.
- R3: Body and tail flits (head marker 0) go to the output their packet's head was accepted into, with the payload unchanged and in the order they were accepted.
- R4: After an output accepts a head flit whose tail marker is 0, it accepts flits only from that input until that input's tail flit is accepted. Flits from any other input that target it are answered with NACK.
- R5: Each output FIFO holds DEPTH flits. A flit that targets a full FIFO is answered with NACK and is not written, so the FIFO contents stay as they were.
- R6: Among head flits that compete in the same cycle for an unlocked output with room, the winner is the first requesting input at or after that output's pointer, counting upward with wrap-around. Each accepted head moves the pointer to the winner plus one. All pointers start at 0.
- R7: A head flit whose route bits name an output number of N_OUT or more is answered with NACK and reaches no output.
- R8: out_valid is high while the output FIFO is non-empty, and out_flit shows its oldest flit. A cycle with out_ack high and out_nack low removes that flit. out_nack high, or out_ack low, leaves the same flit presented.
- R9: While reset is held and right after it, in_ack, in_nack and out_valid are all low, all outputs are unlocked and all FIFOs are empty.
- R10: A body or tail flit from an input that holds no lock on its recorded output is answered with NACK and is not written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_IN | A flit is offered on each input link |
| in_flit | input | N_IN x FLIT_W | Offered flit per input link |
| in_ack | output | N_IN | Flit offered in the previous cycle was accepted |
| in_nack | output | N_IN | Flit offered in the previous cycle was refused |
| out_valid | output | N_OUT | Output FIFO holds a flit |
| out_flit | output | N_OUT x FLIT_W | Oldest flit of each output FIFO |
| out_ack | input | N_OUT | Receiver takes the presented flit |
| out_nack | input | N_OUT | Receiver refuses the presented flit |

## Verification
The hardest case to reach from the ports is the rotation of an output's priority pointer. Seeing it needs two head flits in the very same cycle on an unlocked output, with the pointer at a known value. The bench gets there by sending the same pair of single-flit packets to one fresh output three times in a row. It predicts that the winner alternates and checks both the ACK/NACK split and the order of flits in the FIFO. The lock case is reached by leaving an open packet on an output and offering a competing head before the tail arrives. The full case is reached by holding off out_ack while one input fills the FIFO.

// File: rtl/noc_sw_pkg.sv
package noc_sw_pkg;
  // marker bits sitting above the payload in every flit
  typedef struct packed {
    logic head;
    logic tail;
  } mark_t;

  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/noc_sw_ofifo.sv
module noc_sw_ofifo #(
  parameter int W     = 18,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign do_wr   = wr_en & ~full;
  assign do_rd   = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];

  // storage without reset so it can map onto RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/noc_sw_rr.sv
module noc_sw_rr #(
  parameter int N = 4
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [N-1:0]                          req,
  input  logic                                  adv,
  output logic                                  gnt_any,
  output logic [noc_sw_pkg::sel_width(N)-1:0]   gnt_idx
);
  localparam int IW = noc_sw_pkg::sel_width(N);

  logic [IW-1:0] ptr;
  int            c;

  // first requester at or after the pointer, wrapping
  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    c       = 0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!gnt_any && req[c]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/noc_sw_switch.sv
module noc_sw_switch #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [N_IN-1:0]                   in_valid,
  input  logic [N_IN-1:0][DATA_W+1:0]       in_flit,
  output logic [N_IN-1:0]                   in_ack,
  output logic [N_IN-1:0]                   in_nack,
  output logic [N_OUT-1:0]                  out_valid,
  output logic [N_OUT-1:0][DATA_W+1:0]      out_flit,
  input  logic [N_OUT-1:0]                  out_ack,
  input  logic [N_OUT-1:0]                  out_nack
);
  import noc_sw_pkg::*;

  localparam int FLIT_W = DATA_W + 2;
  localparam int SEL_W  = sel_width(N_OUT);
  localparam int IN_W   = sel_width(N_IN);
  localparam int LVL_W  = $clog2(DEPTH + 1);

  // per-input decode
  logic [N_IN-1:0]   is_head, is_tail;
  logic [SEL_W-1:0]  head_dst [N_IN];
  logic [SEL_W-1:0]  dst_q    [N_IN];
  logic [FLIT_W-1:0] fwd      [N_IN];
  logic [N_IN-1:0]   acc_in;

  // per-output state, visible to the bound checker
  logic              lock_q  [N_OUT];
  logic [IN_W-1:0]   owner_q [N_OUT];
  logic [LVL_W-1:0]  lvl     [N_OUT];
  logic [N_IN-1:0]   acc_m   [N_OUT];

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      is_head[i]  = in_flit[i][FLIT_W-1];
      is_tail[i]  = in_flit[i][FLIT_W-2];
      head_dst[i] = in_flit[i][SEL_W-1:0];
      fwd[i]      = is_head[i]
                  ? {in_flit[i][FLIT_W-1:DATA_W], DATA_W'(in_flit[i][DATA_W-1:0] >> SEL_W)}
                  : in_flit[i];
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_IN-1:0]   hreq;
    logic              own_req, full, empty, gnt_any, adv, take_body;
    logic [IN_W-1:0]   gnt_idx, sel;
    logic [FLIT_W-1:0] head_flit;

    always_comb begin
      for (int i = 0; i < N_IN; i++)
        hreq[i] = in_valid[i] & is_head[i] & (head_dst[i] == SEL_W'(o));
    end

    assign own_req   = in_valid[owner_q[o]] & ~is_head[owner_q[o]]
                     & (dst_q[owner_q[o]] == SEL_W'(o));
    assign adv       = ~lock_q[o] & ~full & gnt_any;
    assign take_body = lock_q[o] & own_req & ~full;
    assign sel       = take_body ? owner_q[o] : gnt_idx;

    always_comb begin
      for (int i = 0; i < N_IN; i++)
        acc_m[o][i] = (adv && gnt_idx == IN_W'(i)) || (take_body && owner_q[o] == IN_W'(i));
    end

    noc_sw_rr #(.N(N_IN)) u_arb (
      .clk     (clk),
      .rst     (rst),
      .req     (hreq),
      .adv     (adv),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        lock_q[o]  <= 1'b0;
        owner_q[o] <= '0;
      end else if (adv && !is_tail[gnt_idx]) begin
        lock_q[o]  <= 1'b1;
        owner_q[o] <= gnt_idx;
      end else if (take_body && is_tail[owner_q[o]]) begin
        lock_q[o]  <= 1'b0;
      end
    end

    noc_sw_ofifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (adv | take_body),
      .wr_data (fwd[sel]),
      .rd_en   (out_ack[o] & ~out_nack[o]),
      .rd_data (head_flit),
      .full    (full),
      .empty   (empty),
      .level   (lvl[o])
    );

    assign out_valid[o] = ~empty;
    assign out_flit[o]  = head_flit;
  end

  always_comb begin
    for (int i = 0; i < N_IN; i++) begin
      acc_in[i] = 1'b0;
      for (int o = 0; o < N_OUT; o++) acc_in[i] = acc_in[i] | acc_m[o][i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_ack  <= '0;
      in_nack <= '0;
      for (int i = 0; i < N_IN; i++) dst_q[i] <= '0;
    end else begin
      in_ack  <= acc_in;
      in_nack <= in_valid & ~acc_in;
      for (int i = 0; i < N_IN; i++)
        if (in_valid[i] && is_head[i] && acc_in[i]) dst_q[i] <= head_dst[i];
    end
  end
endmodule

// File: rtl/noc_sw_switch_chk.sv
module noc_sw_switch_chk #(
  parameter int N_IN   = 4,
  parameter int N_OUT  = 3,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input logic                                           clk,
  input logic                                           rst,
  input logic [N_IN-1:0]                                in_valid,
  input logic [N_IN-1:0][DATA_W+1:0]                    in_flit,
  input logic [N_IN-1:0]                                in_ack,
  input logic [N_IN-1:0]                                in_nack,
  input logic [N_OUT-1:0]                               out_valid,
  input logic [N_OUT-1:0][DATA_W+1:0]                   out_flit,
  input logic [N_OUT-1:0]                               out_ack,
  input logic [N_OUT-1:0]                               out_nack,
  input logic                                           lock_q  [N_OUT],
  input logic [noc_sw_pkg::sel_width(N_IN)-1:0]         owner_q [N_OUT],
  input logic [$clog2(DEPTH+1)-1:0]                     lvl     [N_OUT]
);
  localparam int FLIT_W = DATA_W + 2;
  localparam int SEL_W  = noc_sw_pkg::sel_width(N_OUT);

  // R2: never both answers, and no answer without an offer
  p_ack_nack_excl_r2: assert property (@(posedge clk) disable iff (rst)
    (in_ack & in_nack) == '0);
  p_resp_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ((in_ack | in_nack) & ~$past(in_valid)) == '0);

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    // R7: head with an out-of-range route never accepted
    p_bad_route_r7: assert property (@(posedge clk) disable iff (rst)
      (in_valid[i] && in_flit[i][FLIT_W-1] && (int'(in_flit[i][SEL_W-1:0]) >= N_OUT))
      |=> !in_ack[i]);
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_o
    // R5: FIFO occupancy bounded by its depth
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
      int'(lvl[o]) <= DEPTH);
    // R4: owner fixed while the lock persists
    p_owner_held_r4: assert property (@(posedge clk) disable iff (rst)
      (lock_q[o] && $past(lock_q[o])) |-> $stable(owner_q[o]));
    // R8: presented flit stays until acknowledged
    p_hold_front_r8: assert property (@(posedge clk) disable iff (rst)
      (out_valid[o] && !(out_ack[o] && !out_nack[o])) |=> (out_valid[o] && $stable(out_flit[o])));
  end
endmodule

bind noc_sw_switch noc_sw_switch_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/noc_sw_switch_bench.sv
module noc_sw_switch_bench;
  localparam int N_IN   = 4;
  localparam int N_OUT  = 3;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int FLIT_W = DATA_W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0]                in_valid = '0;
  logic [N_IN-1:0][FLIT_W-1:0]    in_flit  = '0;
  logic [N_IN-1:0]                in_ack, in_nack;
  logic [N_OUT-1:0]               out_valid;
  logic [N_OUT-1:0][FLIT_W-1:0]   out_flit;
  logic [N_OUT-1:0]               out_ack  = '0;
  logic [N_OUT-1:0]               out_nack = '0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  noc_sw_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_noc_sw_switch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_flit(in_flit), .in_ack(in_ack),
    .in_nack(in_nack), .out_valid(out_valid), .out_flit(out_flit), .out_ack(out_ack),
    .out_nack(out_nack)
  );

  function automatic logic [FLIT_W-1:0] mk(input bit h, input bit t, input logic [DATA_W-1:0] p);
    return {h, t, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // offer one flit for one cycle, then check the answer
  task automatic send(input int i, input logic [FLIT_W-1:0] f, input bit exp_ack, input string req);
    in_valid[i] = 1'b1;
    in_flit[i]  = f;
    @(posedge clk); @(negedge clk);
    in_valid[i] = 1'b0;
    chk(in_ack[i] == exp_ack && in_nack[i] == !exp_ack, req,
        {30'd0, in_ack[i], in_nack[i]}, {30'd0, exp_ack, !exp_ack});
  endtask

  // two flits offered in the same cycle
  task automatic send2(input int a, input logic [FLIT_W-1:0] fa, input int b, input logic [FLIT_W-1:0] fb,
                       input int winner, input string req);
    in_valid[a] = 1'b1; in_flit[a] = fa;
    in_valid[b] = 1'b1; in_flit[b] = fb;
    @(posedge clk); @(negedge clk);
    in_valid[a] = 1'b0; in_valid[b] = 1'b0;
    chk(in_ack[a] == (winner == a) && in_nack[a] == (winner != a), req,
        {30'd0, in_ack[a], in_nack[a]}, {30'd0, winner == a, winner != a});
    chk(in_ack[b] == (winner == b) && in_nack[b] == (winner != b), req,
        {30'd0, in_ack[b], in_nack[b]}, {30'd0, winner == b, winner != b});
  endtask

  task automatic pop(input int o, input logic [FLIT_W-1:0] f, input string req);
    chk(out_valid[o] && out_flit[o] == f, req, {13'd0, out_valid[o], out_flit[o]}, {13'd0, 1'b1, f});
    out_ack[o] = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ack[o] = 1'b0;
  endtask

  task automatic expect_empty(input int o, input string req);
    chk(!out_valid[o], req, {31'd0, out_valid[o]}, 32'd0);
  endtask

  task automatic t_reset;
    chk(in_ack == '0 && in_nack == '0 && out_valid == '0, "R9",
        {21'd0, in_ack, in_nack, out_valid}, 32'd0);
  endtask

  task automatic t_single;
    send(0, mk(1, 1, 16'h1235), 1'b1, "R2 single accepted");
    @(posedge clk); @(negedge clk);
    chk(in_ack == '0 && in_nack == '0, "R2 idle no answer", {24'd0, in_ack, in_nack}, 32'd0);
    pop(1, mk(1, 1, 16'h048D), "R1 route shift");
    expect_empty(1, "R1 drained");
    expect_empty(0, "R1 other output untouched");
  endtask

  task automatic t_rotate;
    send2(0, mk(1, 1, 16'h0006), 2, mk(1, 1, 16'h000A), 0, "R6 round1 ptr0");
    send2(0, mk(1, 1, 16'h0006), 2, mk(1, 1, 16'h000A), 2, "R6 round2 ptr1");
    send2(0, mk(1, 1, 16'h000E), 2, mk(1, 1, 16'h000A), 0, "R6 round3 ptr3");
    pop(2, mk(1, 1, 16'h0001), "R6 order 1");
    pop(2, mk(1, 1, 16'h0002), "R6 order 2");
    pop(2, mk(1, 1, 16'h0003), "R6 order 3");
    expect_empty(2, "R6 drained");
  endtask

  task automatic t_packet;
    send(1, mk(1, 0, 16'hC0C0), 1'b1, "R3 head");
    send(1, mk(0, 0, 16'h1111), 1'b1, "R3 body");
    send(1, mk(0, 1, 16'h2222), 1'b1, "R3 tail");
    pop(0, mk(1, 0, 16'h3030), "R3 head out");
    pop(0, mk(0, 0, 16'h1111), "R3 body unchanged");
    pop(0, mk(0, 1, 16'h2222), "R3 tail unchanged");
    expect_empty(0, "R3 drained");
  endtask

  task automatic t_lock;
    send(0, mk(1, 0, 16'h0100), 1'b1, "R4 open packet");
    send(3, mk(1, 1, 16'h0004), 1'b0, "R4 locked out");
    send(0, mk(0, 1, 16'h5555), 1'b1, "R4 owner tail");
    send(3, mk(1, 1, 16'h0004), 1'b1, "R4 after release");
    pop(0, mk(1, 0, 16'h0040), "R4 head");
    pop(0, mk(0, 1, 16'h5555), "R4 tail not interleaved");
    pop(0, mk(1, 1, 16'h0001), "R4 retried packet");
    expect_empty(0, "R4 drained");
  endtask

  task automatic t_full;
    for (int k = 0; k < DEPTH; k++)
      send(3, mk(1, 1, 16'h1001 + 16'(k << 8)), 1'b1, "R5 fill");
    send(3, mk(1, 1, 16'h1F01), 1'b0, "R5 full refused");
    // receiver refuses: front flit stays
    out_ack[1] = 1'b1; out_nack[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ack[1] = 1'b0; out_nack[1] = 1'b0;
    for (int k = 0; k < DEPTH; k++)
      pop(1, mk(1, 1, 16'((16'h1001 + 16'(k << 8)) >> 2)), k == 0 ? "R8 kept after nack" : "R5 contents");
    expect_empty(1, "R5 refused flit not stored");
  endtask

  task automatic t_bad_route;
    send(2, mk(1, 1, 16'h0003), 1'b0, "R7 bad route");
    @(posedge clk); @(negedge clk);
    chk(out_valid == '0, "R7 nothing forwarded", {29'd0, out_valid}, 32'd0);
  endtask

  task automatic t_orphan;
    send(1, mk(0, 1, 16'h7777), 1'b0, "R10 orphan body");
    @(posedge clk); @(negedge clk);
    chk(out_valid == '0, "R10 nothing forwarded", {29'd0, out_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    t_reset();
    t_single();
    t_rotate();
    t_packet();
    t_lock();
    t_full();
    t_bad_route();
    t_orphan();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule